// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a target on a two-wire serial bus (I2C) that fronts a 128-byte memory. It oversamples the clock and data lines with the system clock and finds Start and Stop conditions. It shifts in a control byte, a word address and write data, and it pulls the data line low in the acknowledge slot after each byte it accepts. It drives the data line only through an open-drain enable: a 1 on `sda_oe` pulls the wire low, and a 0 releases it.

Written bytes collect in a 16-byte page buffer, which is aligned to a 16-byte block of memory. The buffer is written into the memory array when the master sends Stop. A busy period then stands in for the programming time. During that period the target ignores its own control byte. A read can follow a write of the address and a repeated Start (a random read), and it can continue byte after byte (a sequential read) until the master leaves a byte unacknowledged.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the target releases the data line (`sda_oe` = 0) and waits for a Start condition.
- R2: The target acknowledges a control byte whose upper four bits are 1010, whatever its bits 3..1 hold. It does not acknowledge any other control byte and then ignores the bus until the next Start. Bit 0 of the control byte selects read (1) or write (0).
- R3: For each accepted control, address or write-data byte, the target pulls the data line low across the whole ninth clock pulse. While SCL is high, `sda_oe` changes only in response to a Start or Stop condition.
- R4: The byte after a write control byte is the word address. Only its low 7 bits are used, and bit 7 is ignored.
- R5: Write-data bytes go to consecutive addresses starting at the word address. Memory changes only when a Stop ends the write.
- R6: The write pointer wraps within the 16-byte block that holds the word address. When more than 16 bytes arrive, each byte past the sixteenth replaces the oldest byte still buffered, so the block holds the last 16 bytes sent.
- R7: From the Stop that commits a write, and for BUSY_CYCLES system clocks after it, the target does not acknowledge a control byte. After that period it acknowledges one again.
- R8: After a read control byte, the target sends the byte at the current address, MSB first. Each bit changes only while SCL is low.
- R9: When the master acknowledges a read byte, the address advances and the next byte follows. The address wraps from 127 to 0.
- R10: When the master does not acknowledge a read byte, the target releases the data line and waits for Stop or Start.
- R11: A Start inside a write discards any buffered bytes and returns to the control-byte phase. A Stop in the middle of a byte drops that partial byte and commits the complete bytes received before it.
- R12: A Stop that comes after the address byte, with no data byte, commits nothing and starts no busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
A corrupted bit counter or state register shows up at the next acknowledge slot. The master then samples a released line where it expected a low, or the reverse, within one byte time (nine SCL pulses). A wrong page-buffer pointer or lost valid bit stays hidden until a later read returns the wrong byte. For that reason every write in the bench is followed by a read-back of the written addresses, including the rollover and abort cases. A busy timer that runs too short or too long shows up as an acknowledge where a refusal was expected, or the reverse, on the first control byte after the committing Stop.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } eep_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam logic [3:0] BIT_LAST = 4'd8;  // count after 8 data rises
  localparam logic [3:0] BIT_ACK  = 4'd9;  // count after the ninth rise
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_s_n,
  output logic scl_hi,
  output logic sda_hi,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic [1:0]           rst_pipe;
  logic [SYNC_STAGES:0] scl_pipe;
  logic [SYNC_STAGES:0] sda_pipe;
  logic scl_prev, sda_prev;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // synchronizer stages plus one history stage; the idle bus is high
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_hi   = scl_pipe[SYNC_STAGES-1];
  assign sda_hi   = sda_pipe[SYNC_STAGES-1];
  assign scl_prev = scl_pipe[SYNC_STAGES];
  assign sda_prev = sda_pipe[SYNC_STAGES];

  assign start_ev = scl_hi & scl_prev & sda_prev & ~sda_hi;
  assign stop_ev  = scl_hi & scl_prev & ~sda_prev & sda_hi;
  assign scl_rise = scl_hi & ~scl_prev;
  assign scl_fall = ~scl_hi & scl_prev;
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int BUSY_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = CW'(BUSY_CYCLES);
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R7: a committing Stop opens the programming window on the next cycle
  a_r7_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [$clog2(PAGE_BYTES)-1:0] base_lo,
  input  logic                    push,
  input  logic [7:0]              push_data,
  output logic [PAGE_BYTES*8-1:0] slot_data,
  output logic [PAGE_BYTES-1:0]   slot_vld
);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [7:0]    slot_q [PAGE_BYTES];
  logic [PW-1:0] wr_idx_q, wr_idx_d;
  logic [PAGE_BYTES-1:0] vld_d;

  always_comb begin
    wr_idx_d = wr_idx_q;
    vld_d    = slot_vld;
    if (clr) begin
      wr_idx_d = base_lo;
      vld_d    = '0;
    end else if (push) begin
      wr_idx_d         = wr_idx_q + 1'b1;  // rolls over inside the page
      vld_d[wr_idx_q]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      slot_vld <= '0;
    end else begin
      wr_idx_q <= wr_idx_d;
      slot_vld <= vld_d;
    end
  end

  // data storage has no reset; the valid bits qualify it
  always_ff @(posedge clk) begin
    if (push && !clr) slot_q[wr_idx_q] <= push_data;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign slot_data[g*8 +: 8] = slot_q[g];
  end

  // R6: a new address phase empties the page
  a_r6_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (slot_vld == '0));
  // R6: every pushed byte marks the slot it landed in
  a_r6_slot_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |=> slot_vld[$past(wr_idx_q)]);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int MEM_DEPTH  = 128,
  parameter int PAGE_BYTES = 16
) (
  input  logic                                      clk,
  input  logic                                      commit,
  input  logic [$clog2(MEM_DEPTH)-$clog2(PAGE_BYTES)-1:0] page_hi,
  input  logic [PAGE_BYTES*8-1:0]                   slot_data,
  input  logic [PAGE_BYTES-1:0]                     slot_vld,
  input  logic [$clog2(MEM_DEPTH)-1:0]              rd_addr,
  output logic [7:0]                                rd_data
);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [7:0] mem_q [MEM_DEPTH];

  // the whole page lands in one cycle
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (slot_vld[i]) mem_q[{page_hi, PW'(i)}] <= slot_data[i*8 +: 8];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int BUSY_CYCLES = 5000,
  parameter int MEM_DEPTH   = 128,
  parameter int PAGE_BYTES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import eep_pkg::*;

  localparam int AW = $clog2(MEM_DEPTH);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HW = AW - PW;

  logic rst_s_n, scl_hi, sda_hi, start_ev, stop_ev, scl_rise, scl_fall;
  logic busy, commit, buf_clr, buf_push;
  logic [PAGE_BYTES*8-1:0] slot_data;
  logic [PAGE_BYTES-1:0]   slot_vld;
  logic [7:0]              rd_data;

  eep_state_e    state_q, state_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [7:0]    shreg_q, shreg_d;
  logic [7:0]    out_q, out_d;
  logic          ack_q, ack_d;
  logic          mnack_q, mnack_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [HW-1:0] page_q, page_d;

  eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .rst_s_n(rst_s_n), .scl_hi(scl_hi), .sda_hi(sda_hi),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  eep_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk(clk), .rst_n(rst_s_n), .clr(buf_clr), .base_lo(shreg_q[PW-1:0]),
    .push(buf_push), .push_data(shreg_q),
    .slot_data(slot_data), .slot_vld(slot_vld)
  );

  eep_array #(.MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk(clk), .commit(commit), .page_hi(page_q),
    .slot_data(slot_data), .slot_vld(slot_vld),
    .rd_addr(addr_q), .rd_data(rd_data)
  );

  eep_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_s_n), .load(commit), .busy(busy)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    out_d    = out_q;
    ack_d    = ack_q;
    mnack_d  = mnack_q;
    addr_d   = addr_q;
    page_d   = page_q;
    commit   = 1'b0;
    buf_clr  = 1'b0;
    buf_push = 1'b0;

    if (start_ev) begin
      state_d = ST_CTRL;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else if (stop_ev) begin
      commit  = (state_q == ST_WDATA) && (slot_vld != '0);
      state_d = ST_IDLE;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (cnt_q < BIT_LAST)       shreg_d = {shreg_q[6:0], sda_hi};
        else if (cnt_q == BIT_LAST) mnack_d = sda_hi;
        if (cnt_q != BIT_ACK)       cnt_d   = cnt_q + 1'b1;
      end else if (scl_fall) begin
        if (cnt_q == BIT_LAST) begin
          // open the ninth slot
          unique case (state_q)
            ST_CTRL:           ack_d = (shreg_q[7:4] == DEV_CODE) && !busy;
            ST_ADDR, ST_WDATA: ack_d = 1'b1;
            default:           out_d = 8'hFF;  // read: hand the line to the master
          endcase
        end else if (cnt_q == BIT_ACK) begin
          ack_d = 1'b0;
          cnt_d = '0;
          unique case (state_q)
            ST_CTRL: begin
              if (!ack_q) begin
                state_d = ST_IDLE;
              end else if (shreg_q[0]) begin
                state_d = ST_RDATA;
                out_d   = rd_data;
                addr_d  = addr_q + 1'b1;
              end else begin
                state_d = ST_ADDR;
              end
            end
            ST_ADDR: begin
              addr_d  = shreg_q[AW-1:0];
              page_d  = shreg_q[AW-1:PW];
              buf_clr = 1'b1;
              state_d = ST_WDATA;
            end
            ST_WDATA: buf_push = 1'b1;
            ST_RDATA: begin
              if (mnack_q) begin
                state_d = ST_IDLE;
              end else begin
                out_d  = rd_data;
                addr_d = addr_q + 1'b1;
              end
            end
            default: state_d = ST_IDLE;
          endcase
        end else if (state_q == ST_RDATA) begin
          out_d = {out_q[6:0], 1'b1};
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      out_q   <= 8'hFF;
      ack_q   <= 1'b0;
      mnack_q <= 1'b1;
      addr_q  <= '0;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      out_q   <= out_d;
      ack_q   <= ack_d;
      mnack_q <= mnack_d;
      addr_q  <= addr_d;
      page_q  <= page_d;
    end
  end

  assign sda_oe = ack_q | ((state_q == ST_RDATA) & ~out_q[7]);

  // R3: the line is never moved by the target while SCL is high
  a_r3_steady_high: assert property (@(posedge clk) disable iff (!rst_s_n)
    (scl_hi && $past(scl_hi) && !$past(start_ev) && !$past(stop_ev))
      |-> $stable(sda_oe));
  // R7: no acknowledge of the control byte inside the programming window
  a_r7_silent_busy: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && state_q == ST_CTRL) |-> !ack_q);
  // R10: once back at idle (after a master NACK or a refusal) the line is free
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_IDLE) |-> !sda_oe);
  // R12: the programming window opens only out of a data phase
  a_r12_busy_from_write: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(busy) |-> ($past(state_q) == ST_WDATA));
endmodule

// File: tb/tb_i2c_eeprom_target.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_target;
  localparam int BUSY = 1000;
  localparam int H    = 20;
  localparam int Q    = 10;
  // {word address, data}: single-byte writes later read back
  localparam logic [14:0] VEC [6] = '{
    {7'h7F, 8'h5A}, {7'h00, 8'hC3}, {7'h40, 8'h77},
    {7'h41, 8'h10}, {7'h15, 8'hE1}, {7'h33, 8'h0F}
  };

  logic clk, rst_n, scl, m_low, sda_oe, sda_line;
  int n_checks, n_fail;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  assign sda_line = ~(sda_oe | m_low);

  i2c_eeprom_target #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_start();
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(H);
    m_low = 1'b1; tick(H); scl = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(H);
    m_low = 1'b0; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      tick(Q); m_low = ~b[7-i]; tick(Q);
      scl = 1'b1; tick(H); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    tick(Q); m_low = 1'b0; tick(Q);
    scl = 1'b1; tick(Q); ack = ~sda_line; tick(Q); scl = 1'b0;
  endtask

  task automatic read_byte(input logic ack_it, output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(H); scl = 1'b1; tick(Q); d[7-i] = sda_line; tick(Q); scl = 1'b0;
    end
    tick(Q); m_low = ack_it; tick(Q);
    scl = 1'b1; tick(H); scl = 1'b0; tick(Q); m_low = 1'b0;
  endtask

  task automatic write_seq(input logic [7:0] addr, input int n);
    logic a;
    m_start();
    send_byte(8'hA0, a); chk("R3 ctrl ack", a, 1);
    send_byte(addr, a);  chk("R3 addr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); chk("R3 data ack", a, 1);
    end
    m_stop();
  endtask

  task automatic rnd_read(input logic [7:0] addr, input int n);
    logic a;
    m_start();
    send_byte(8'hA0, a); chk("R8 ctrl ack", a, 1);
    send_byte(addr, a);  chk("R8 addr ack", a, 1);
    m_start();
    send_byte(8'hA1, a); chk("R8 read ctrl ack", a, 1);
    for (int i = 0; i < n; i++) read_byte(i != n - 1, rbuf[i]);
    m_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog req=all actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 line idle high", sda_line, 1);

    // vector table: write one byte, wait, random read it back
    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][7:0];
      write_seq({1'b0, VEC[v][14:8]}, 1);
      tick(BUSY + 100);
      rnd_read({1'b0, VEC[v][14:8]}, 1);
      chk("R5 R8 single write readback", rbuf[0], VEC[v][7:0]);
    end

    // R2: wrong device code refused, then don't-care bits accepted
    m_start(); send_byte(8'hB0, a); chk("R2 wrong code nack", a, 0); m_stop();
    m_start(); send_byte(8'hAE, a); chk("R2 dont-care bits ack", a, 1);
    send_byte(8'h10, a); chk("R3 addr ack", a, 1);
    m_stop();
    // R12: no data, so no busy period: read control acked at once
    m_start(); send_byte(8'hA1, a); chk("R12 no busy after address-only", a, 1);
    read_byte(1'b0, d);
    chk("R10 released after master nack", sda_oe, 0);
    m_stop();

    // R6: 20 bytes into a 16-byte block
    for (int i = 0; i < 20; i++) wbuf[i] = 8'h80 + 8'(i);
    write_seq(8'h20, 20);
    m_start(); send_byte(8'hA0, a); chk("R7 nack while busy", a, 0); m_stop();
    tick(BUSY + 100);
    m_start(); send_byte(8'hA0, a); chk("R7 ack after busy", a, 1); m_stop();
    rnd_read(8'h20, 16);
    for (int i = 0; i < 16; i++)
      chk("R6 page rollover", rbuf[i], (i < 4) ? 8'h90 + 8'(i) : 8'h80 + 8'(i));

    // R4 R9: address MSB ignored, sequential read wraps 127 -> 0
    rnd_read(8'hFF, 2);
    chk("R4 R9 byte at 127", rbuf[0], 8'h5A);
    chk("R9 wrap to 0", rbuf[1], 8'hC3);

    // R11: Start inside a data byte discards the write
    m_start(); send_byte(8'hA0, a); send_byte(8'h40, a); send_byte(8'h99, a);
    send_bits(8'h55, 4);
    m_start(); m_stop();
    m_start(); send_byte(8'hA0, a); chk("R11 abort starts no busy", a, 1); m_stop();
    rnd_read(8'h40, 1);
    chk("R11 start abort keeps memory", rbuf[0], 8'h77);

    // R11: Stop inside a data byte keeps the complete bytes
    m_start(); send_byte(8'hA0, a); send_byte(8'h41, a); send_byte(8'h3C, a);
    send_bits(8'hF0, 3);
    m_stop();
    tick(BUSY + 100);
    rnd_read(8'h41, 1);
    chk("R11 stop mid-byte commits whole bytes", rbuf[0], 8'h3C);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule